// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns an effective address into a real address by walking a radix tree of translation tables held in memory. Software, or an upstream translation unit, supplies the root table base, the index width of the root table and the total number of address bits the tree translates. The walker then reads one 64-bit table entry per level over a request/acknowledge memory port. A non-leaf entry names the next table and its index width. A leaf entry ends the walk.

At each level the index is a window of the effective address. The window's top edge sits at the remaining translated size and its width is the current index width. The remaining size then shrinks by that width, so the size left over when a leaf is reached is the page size. The walk reports the real address, the page size, the leaf entry and the leaf entry's address, or a fault vector. Only one walk runs at a time.

Entry layout: bit 63 marks a valid entry and bit 62 marks a leaf. In a directory entry, bits 55:8 give the next table base (the low eight bits are taken as zero) and bits 4:0 give the next index width. In a leaf entry, bits 55:12 give the real page number. Fault bit 0 means bad configuration and fault bit 1 means a missing entry.

Top module: `rtw_walker`

## Requirements
- R1: While reset is held and after its release, `busy`, `done`, `mem_req` and `fault` are all low until a start is accepted.
- R2: Each entry read goes to base + 8 × ((EA >> (size − width)) & (2^width − 1)), where size is the remaining translated size and width is the current index width. Every request address is 8-byte aligned.
- R3: A valid entry with bit 62 clear is a directory entry. The next base is its bits 55:8 with bits 7:0 forced to zero, so bits 7:5 are ignored. The next index width is its bits 4:0. The remaining size is reduced by the index width just used.
- R4: At a valid leaf entry (bits 63 and 62 set), `page_size` is the remaining size minus the current width. `raddr` takes bits 55:12 of the entry above `page_size` and the effective address bits below it. `leaf_pte` and `leaf_addr` report the entry and its address, and `fault` is 2'b00.
- R5: An index width below 5 ends the walk with `fault` = 2'b01 and no read for that level.
- R6: A fetched entry with bit 63 clear ends the walk with `fault` = 2'b10.
- R7: An index width larger than the remaining size ends the walk with `fault` = 2'b01 and no read. A width equal to the remaining size is legal and gives a zero page size.
- R8: At most MAX_LEVELS (default 8) entries are read per walk. A directory entry found at the last allowed level ends the walk with `fault` = 2'b01. A leaf at that level completes normally.
- R9: `mem_req` and `mem_addr` stay steady until `mem_ack`. A `start` while `busy` is high is ignored, and the running walk's result is unchanged.
- R10: `busy` rises in the cycle after an accepted `start` and stays high through a single-cycle `done` pulse. The result outputs hold after `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk when idle |
| ea | input | 64 | Effective address to translate |
| root_base | input | 56 | Root table base address |
| root_nls | input | 5 | Root table index width |
| tot_size | input | 6 | Total translated size in bits |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 56 | Entry read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 64 | Read data |
| fault | output | 2 | Fault cause: bit 0 bad configuration, bit 1 missing entry |
| raddr | output | 56 | Translated real address |
| page_size | output | 6 | Final page size in bits |
| leaf_pte | output | 64 | Leaf entry |
| leaf_addr | output | 56 | Address of the leaf entry |

## Verification
Walks of two and three levels with unequal index widths check the sliding index window and the shrinking size, since a wrong shift or subtraction changes both the read addresses and the page size. A leaf at the root, and a root width equal to the total size, pin the page-size arithmetic at its large and zero extremes. Chains of seven and eight directories separate "leaf at the last allowed level" from "directory at the last level". Faulting walks with widths that are too small, widths larger than the remaining size and invalid entries are told apart by the fault code and by how many reads were issued. A slow memory and a start issued mid-walk show that requests are held and that a second walk cannot disturb the first.

// File: rtl/rtw_pkg.sv
package rtw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CHK  = 2'd1,
    ST_REQ  = 2'd2,
    ST_DONE = 2'd3
  } walk_st_e;

  localparam int FLT_W      = 2;
  localparam int FLT_BADCFG = 0;
  localparam int FLT_NOPTE  = 1;

  localparam int ENT_VALID  = 63;
  localparam int ENT_LEAF   = 62;
  localparam int BASE_LSB   = 8;
  localparam int RPN_LSB    = 12;
  localparam int MIN_NLS    = 5;
endpackage

// File: rtl/rtw_index_gen.sv
// Forms the entry address for the current level and flags widths that
// cannot index a table (too narrow, or wider than the bits still left).
module rtw_index_gen
  import rtw_pkg::*;
#(
  parameter int EA_W  = 64,
  parameter int PA_W  = 56,
  parameter int SZ_W  = 6,
  parameter int NLS_W = 5
) (
  input  logic [EA_W-1:0]  ea,
  input  logic [PA_W-1:0]  base,
  input  logic [SZ_W-1:0]  size,
  input  logic [NLS_W-1:0] nls,
  output logic [PA_W-1:0]  ent_addr,
  output logic             cfg_bad
);
  localparam int ENT_BYTES_LG = 3;

  logic [SZ_W-1:0] shamt;
  logic [EA_W-1:0] win;
  logic [EA_W-1:0] idx_mask;
  logic [EA_W-1:0] idx;
  logic [EA_W-1:0] offset;
  logic            too_narrow;
  logic            too_wide;

  always_comb begin
    shamt      = size - SZ_W'(nls);
    win        = ea >> shamt;
    idx_mask   = (EA_W'(1) << nls) - EA_W'(1);
    idx        = win & idx_mask;
    offset     = idx << ENT_BYTES_LG;
    ent_addr   = base + PA_W'(offset);
    too_narrow = (nls < NLS_W'(MIN_NLS));
    too_wide   = (SZ_W'(nls) > size);
    cfg_bad    = too_narrow | too_wide;
  end
endmodule

// File: rtl/rtw_entry_decode.sv
// Splits a fetched entry into its flags, the next-table fields and the
// real address that a leaf would produce for the given page size.
module rtw_entry_decode
  import rtw_pkg::*;
#(
  parameter int EA_W  = 64,
  parameter int PA_W  = 56,
  parameter int SZ_W  = 6,
  parameter int NLS_W = 5,
  parameter int ENT_W = 64
) (
  input  logic [ENT_W-1:0] ent,
  input  logic [EA_W-1:0]  ea,
  input  logic [SZ_W-1:0]  psize,
  output logic             vld,
  output logic             leaf,
  output logic [PA_W-1:0]  next_base,
  output logic [NLS_W-1:0] next_nls,
  output logic [PA_W-1:0]  raddr
);
  localparam logic [PA_W-1:0] BASE_KEEP = ~PA_W'((64'd1 << BASE_LSB) - 64'd1);
  localparam logic [PA_W-1:0] RPN_KEEP  = ~PA_W'((64'd1 << RPN_LSB) - 64'd1);

  logic [EA_W-1:0] pmask;
  logic [PA_W-1:0] rpn;
  logic [PA_W-1:0] low_mask;

  always_comb begin
    vld       = ent[ENT_VALID];
    leaf      = ent[ENT_LEAF];
    next_nls  = NLS_W'(ent);
    next_base = PA_W'(ent) & BASE_KEEP;
    rpn       = PA_W'(ent) & RPN_KEEP;
    pmask     = (EA_W'(1) << psize) - EA_W'(1);
    low_mask  = PA_W'(pmask);
    raddr     = (rpn & ~low_mask) | (PA_W'(ea) & low_mask);
  end
endmodule

// File: rtl/rtw_ctrl.sv
// Walk sequencer: holds the per-level state, drives the memory port and
// captures the result or fault.
module rtw_ctrl
  import rtw_pkg::*;
#(
  parameter int EA_W       = 64,
  parameter int PA_W       = 56,
  parameter int SZ_W       = 6,
  parameter int NLS_W      = 5,
  parameter int ENT_W      = 64,
  parameter int MAX_LEVELS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [EA_W-1:0]   ea_in,
  input  logic [PA_W-1:0]   root_base,
  input  logic [NLS_W-1:0]  root_nls,
  input  logic [SZ_W-1:0]   tot_size,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_ack,
  input  logic [ENT_W-1:0]  mem_rdata,
  output logic [EA_W-1:0]   cur_ea,
  output logic [PA_W-1:0]   cur_base,
  output logic [NLS_W-1:0]  cur_nls,
  output logic [SZ_W-1:0]   cur_size,
  output logic [SZ_W-1:0]   rem_size,
  input  logic [PA_W-1:0]   gen_addr,
  input  logic              gen_bad,
  input  logic              dec_vld,
  input  logic              dec_leaf,
  input  logic [PA_W-1:0]   dec_base,
  input  logic [NLS_W-1:0]  dec_nls,
  input  logic [PA_W-1:0]   dec_raddr,
  output logic [FLT_W-1:0]  fault,
  output logic [PA_W-1:0]   raddr,
  output logic [SZ_W-1:0]   page_size,
  output logic [ENT_W-1:0]  leaf_pte,
  output logic [PA_W-1:0]   leaf_addr
);
  localparam int LVL_W = $clog2(MAX_LEVELS + 1);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(MAX_LEVELS - 1);

  walk_st_e          st_q, st_d;
  logic [EA_W-1:0]   ea_q;
  logic [PA_W-1:0]   base_q, base_d;
  logic [NLS_W-1:0]  nls_q, nls_d;
  logic [SZ_W-1:0]   size_q, size_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [PA_W-1:0]   addr_q;
  logic [FLT_W-1:0]  flt_q, flt_d;
  logic [PA_W-1:0]   ra_q;
  logic [SZ_W-1:0]   ps_q;
  logic [ENT_W-1:0]  pte_q;
  logic [PA_W-1:0]   la_q;

  logic walk_ld, step_ld, addr_ld, flt_ld, res_ld;

  assign rem_size = size_q - SZ_W'(nls_q);

  // next-state and enables
  always_comb begin
    st_d    = st_q;
    walk_ld = 1'b0;
    step_ld = 1'b0;
    addr_ld = 1'b0;
    flt_ld  = 1'b0;
    res_ld  = 1'b0;
    flt_d   = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          walk_ld = 1'b1;
          st_d    = ST_CHK;
        end
      end
      ST_CHK: begin
        if (gen_bad) begin
          flt_ld             = 1'b1;
          flt_d[FLT_BADCFG]  = 1'b1;
          st_d               = ST_DONE;
        end else begin
          addr_ld = 1'b1;
          st_d    = ST_REQ;
        end
      end
      ST_REQ: begin
        if (mem_ack) begin
          if (!dec_vld) begin
            flt_ld            = 1'b1;
            flt_d[FLT_NOPTE]  = 1'b1;
            st_d              = ST_DONE;
          end else if (dec_leaf) begin
            res_ld = 1'b1;
            st_d   = ST_DONE;
          end else if (lvl_q == LAST_LVL) begin
            flt_ld            = 1'b1;
            flt_d[FLT_BADCFG] = 1'b1;
            st_d              = ST_DONE;
          end else begin
            step_ld = 1'b1;
            st_d    = ST_CHK;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // per-level data selection
  always_comb begin
    base_d = base_q;
    nls_d  = nls_q;
    size_d = size_q;
    lvl_d  = lvl_q;
    if (walk_ld) begin
      base_d = root_base;
      nls_d  = root_nls;
      size_d = tot_size;
      lvl_d  = '0;
    end else if (step_ld) begin
      base_d = dec_base;
      nls_d  = dec_nls;
      size_d = rem_size;
      lvl_d  = lvl_q + LVL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q   <= '0;
      base_q <= '0;
      nls_q  <= '0;
      size_q <= '0;
      lvl_q  <= '0;
    end else begin
      if (walk_ld) ea_q <= ea_in;
      if (walk_ld || step_ld) begin
        base_q <= base_d;
        nls_q  <= nls_d;
        size_q <= size_d;
        lvl_q  <= lvl_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_ld) begin
      addr_q <= gen_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= '0;
    end else if (walk_ld) begin
      flt_q <= '0;
    end else if (flt_ld) begin
      flt_q <= flt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q  <= '0;
      ps_q  <= '0;
      pte_q <= '0;
      la_q  <= '0;
    end else if (walk_ld) begin
      ra_q  <= '0;
      ps_q  <= '0;
      pte_q <= '0;
      la_q  <= '0;
    end else if (res_ld) begin
      ra_q  <= dec_raddr;
      ps_q  <= rem_size;
      pte_q <= mem_rdata;
      la_q  <= addr_q;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign mem_req   = (st_q == ST_REQ);
  assign mem_addr  = addr_q;
  assign cur_ea    = ea_q;
  assign cur_base  = base_q;
  assign cur_nls   = nls_q;
  assign cur_size  = size_q;
  assign fault     = flt_q;
  assign raddr     = ra_q;
  assign page_size = ps_q;
  assign leaf_pte  = pte_q;
  assign leaf_addr = la_q;
endmodule

// File: rtl/rtw_walker.sv
module rtw_walker
  import rtw_pkg::*;
#(
  parameter int EA_W       = 64,
  parameter int PA_W       = 56,
  parameter int SZ_W       = 6,
  parameter int NLS_W      = 5,
  parameter int ENT_W      = 64,
  parameter int MAX_LEVELS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [EA_W-1:0]   ea,
  input  logic [PA_W-1:0]   root_base,
  input  logic [NLS_W-1:0]  root_nls,
  input  logic [SZ_W-1:0]   tot_size,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_ack,
  input  logic [ENT_W-1:0]  mem_rdata,
  output logic [FLT_W-1:0]  fault,
  output logic [PA_W-1:0]   raddr,
  output logic [SZ_W-1:0]   page_size,
  output logic [ENT_W-1:0]  leaf_pte,
  output logic [PA_W-1:0]   leaf_addr
);
  logic [EA_W-1:0]  cur_ea;
  logic [PA_W-1:0]  cur_base;
  logic [NLS_W-1:0] cur_nls;
  logic [SZ_W-1:0]  cur_size;
  logic [SZ_W-1:0]  rem_size;
  logic [PA_W-1:0]  gen_addr;
  logic             gen_bad;
  logic             dec_vld;
  logic             dec_leaf;
  logic [PA_W-1:0]  dec_base;
  logic [NLS_W-1:0] dec_nls;
  logic [PA_W-1:0]  dec_raddr;

  rtw_index_gen #(
    .EA_W(EA_W), .PA_W(PA_W), .SZ_W(SZ_W), .NLS_W(NLS_W)
  ) u_idx (
    .ea       (cur_ea),
    .base     (cur_base),
    .size     (cur_size),
    .nls      (cur_nls),
    .ent_addr (gen_addr),
    .cfg_bad  (gen_bad)
  );

  rtw_entry_decode #(
    .EA_W(EA_W), .PA_W(PA_W), .SZ_W(SZ_W), .NLS_W(NLS_W), .ENT_W(ENT_W)
  ) u_dec (
    .ent       (mem_rdata),
    .ea        (cur_ea),
    .psize     (rem_size),
    .vld       (dec_vld),
    .leaf      (dec_leaf),
    .next_base (dec_base),
    .next_nls  (dec_nls),
    .raddr     (dec_raddr)
  );

  rtw_ctrl #(
    .EA_W(EA_W), .PA_W(PA_W), .SZ_W(SZ_W), .NLS_W(NLS_W), .ENT_W(ENT_W),
    .MAX_LEVELS(MAX_LEVELS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ea_in     (ea),
    .root_base (root_base),
    .root_nls  (root_nls),
    .tot_size  (tot_size),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .cur_ea    (cur_ea),
    .cur_base  (cur_base),
    .cur_nls   (cur_nls),
    .cur_size  (cur_size),
    .rem_size  (rem_size),
    .gen_addr  (gen_addr),
    .gen_bad   (gen_bad),
    .dec_vld   (dec_vld),
    .dec_leaf  (dec_leaf),
    .dec_base  (dec_base),
    .dec_nls   (dec_nls),
    .dec_raddr (dec_raddr),
    .fault     (fault),
    .raddr     (raddr),
    .page_size (page_size),
    .leaf_pte  (leaf_pte),
    .leaf_addr (leaf_addr)
  );
endmodule

// File: rtl/rtw_walker_chk.sv
module rtw_walker_chk #(
  parameter int PA_W       = 56,
  parameter int ENT_W      = 64,
  parameter int MAX_LEVELS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             mem_req,
  input logic [PA_W-1:0]  mem_addr,
  input logic             mem_ack,
  input logic [1:0]       fault,
  input logic [ENT_W-1:0] leaf_pte
);
  logic [7:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt <= '0;
    end else if (start && !busy) begin
      rd_cnt <= '0;
    end else if (mem_req && mem_ack) begin
      rd_cnt <= rd_cnt + 8'd1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done));

  assert_addr_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[2:0] == 3'b000));

  assert_leaf_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == 2'b00) |-> (leaf_pte[63] && leaf_pte[62]));

  assert_one_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0(fault));

  assert_depth_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= 8'(MAX_LEVELS));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind rtw_walker rtw_walker_chk #(
  .PA_W(PA_W), .ENT_W(ENT_W), .MAX_LEVELS(MAX_LEVELS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .mem_ack  (mem_ack),
  .fault    (fault),
  .leaf_pte (leaf_pte)
);

// File: tb/rtw_walker_test.sv
`timescale 1ns/1ps
module rtw_walker_test;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [63:0] ea;
  logic [55:0] root_base;
  logic [4:0]  root_nls;
  logic [5:0]  tot_size;
  logic        busy, done, mem_req, mem_ack;
  logic [55:0] mem_addr;
  logic [63:0] mem_rdata;
  logic [1:0]  fault;
  logic [55:0] raddr, leaf_addr;
  logic [5:0]  page_size;
  logic [63:0] leaf_pte;

  int checks = 0;
  int errors = 0;

  rtw_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .root_base(root_base),
    .root_nls(root_nls), .tot_size(tot_size), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .fault(fault), .raddr(raddr),
    .page_size(page_size), .leaf_pte(leaf_pte), .leaf_addr(leaf_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // memory model
  logic [63:0] mem [logic [55:0]];
  int          lat = 0;
  int          wcnt = 0;
  int          rd_total = 0;
  int          hold_err = 0;
  logic [55:0] held_addr = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack   = 1'b0;
      mem_rdata = '0;
      wcnt      = 0;
    end else if (mem_req && !mem_ack) begin
      if (wcnt > 0 && mem_addr != held_addr) hold_err++;
      held_addr = mem_addr;
      if (wcnt >= lat) begin
        mem_ack   = 1'b1;
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 64'd0;
        rd_total++;
        wcnt      = 0;
      end else begin
        wcnt++;
      end
    end else begin
      if (wcnt > 0) hold_err++;
      mem_ack = 1'b0;
      wcnt    = 0;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected-value helpers from the requirement formulas
  function automatic logic [55:0] f_addr(input logic [55:0] base,
      input logic [63:0] a, input int size, input int nls);
    logic [63:0] idx;
    idx = (a >> (size - nls)) & ((64'd1 << nls) - 64'd1);
    return base + 56'(idx * 8);
  endfunction

  function automatic logic [55:0] f_raddr(input logic [63:0] pte,
      input logic [63:0] a, input int ps);
    logic [55:0] rpn, m;
    rpn = pte[55:0] & ~56'hFFF;
    m   = 56'((64'd1 << ps) - 64'd1);
    return (rpn & ~m) | (a[55:0] & m);
  endfunction

  int          nl [0:8];
  logic [55:0] exp_la;
  int          exp_ps;

  // lays out ndir directory levels then a leaf entry; bits 7:5 carry junk
  task automatic build(input logic [63:0] a, input int size,
                       input logic [55:0] base0, input int ndir,
                       input logic [63:0] leaf);
    logic [55:0] b, nb, ad;
    int s;
    b = base0;
    s = size;
    for (int i = 0; i < ndir; i++) begin
      ad = f_addr(b, a, s, nl[i]);
      nb = 56'h100000 * 56'(i + 2);
      mem[ad] = 64'h8000_0000_0000_0000 | 64'(nb) | 64'hE0 | 64'(nl[i+1]);
      s = s - nl[i];
      b = nb;
    end
    ad = f_addr(b, a, s, nl[ndir]);
    mem[ad] = leaf;
    exp_la = ad;
    exp_ps = s - nl[ndir];
  endtask

  task automatic run_walk(input logic [63:0] a, input logic [55:0] base,
                          input int nls, input int size, output int reads);
    int n;
    int r0;
    r0 = rd_total;
    @(negedge clk);
    ea = a; root_base = base; root_nls = 5'(nls); tot_size = 6'(size);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      errors++;
      $display("FAIL R10 walk timeout: actual no done expected done");
    end
    reads = rd_total - r0;
  endtask

  task automatic t_reset();
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "mem_req", 64'(mem_req), 64'd0);
    chk("R1", "fault", 64'(fault), 64'd0);
  endtask

  task automatic t_two_level();
    logic [63:0] a = 64'h0000_0000_2345_6789;
    logic [63:0] lf = 64'hC000_0000_ABCD_E1F5;
    int rd;
    mem.delete();
    nl[0] = 9; nl[1] = 9;
    build(a, 30, 56'h100000, 1, lf);
    run_walk(a, 56'h100000, 9, 30, rd);
    chk("R4", "fault", 64'(fault), 64'd0);
    chk("R4", "page_size", 64'(page_size), 64'd12);
    chk("R4", "raddr", 64'(raddr), 64'(f_raddr(lf, a, 12)));
    chk("R4", "leaf_pte", leaf_pte, lf);
    chk("R2", "leaf_addr", 64'(leaf_addr), 64'(exp_la));
    chk("R3", "reads", 64'(rd), 64'd2);
    @(negedge clk);
    chk("R10", "busy after done", 64'(busy), 64'd0);
    chk("R10", "result held", 64'(raddr), 64'(f_raddr(lf, a, 12)));
  endtask

  task automatic t_three_level();
    logic [63:0] a = 64'h000A_BCDE_F012_3456;
    logic [63:0] lf = 64'hC000_1234_5678_9000;
    int rd;
    mem.delete();
    nl[0] = 13; nl[1] = 5; nl[2] = 6;
    build(a, 52, 56'h100000, 2, lf);
    run_walk(a, 56'h100000, 13, 52, rd);
    chk("R3", "fault", 64'(fault), 64'd0);
    chk("R3", "page_size", 64'(page_size), 64'(exp_ps));
    chk("R4", "raddr", 64'(raddr), 64'(f_raddr(lf, a, exp_ps)));
    chk("R2", "leaf_addr", 64'(leaf_addr), 64'(exp_la));
    chk("R3", "reads", 64'(rd), 64'd3);
  endtask

  task automatic t_root_leaf();
    logic [63:0] a = 64'h0000_0000_3FFF_FFFF;
    logic [63:0] lf = 64'hC000_00FF_FFE0_0000;
    int rd;
    mem.delete();
    nl[0] = 9;
    build(a, 30, 56'h100000, 0, lf);
    run_walk(a, 56'h100000, 9, 30, rd);
    chk("R4", "root leaf page_size", 64'(page_size), 64'd21);
    chk("R4", "root leaf raddr", 64'(raddr), 64'(f_raddr(lf, a, 21)));
    chk("R4", "root leaf reads", 64'(rd), 64'd1);
  endtask

  task automatic t_exact_width();
    logic [63:0] a = 64'h0000_0000_0000_0ABC;
    logic [63:0] lf = 64'hC000_0000_5555_5000;
    int rd;
    mem.delete();
    nl[0] = 12;
    build(a, 12, 56'h100000, 0, lf);
    run_walk(a, 56'h100000, 12, 12, rd);
    chk("R7", "equal width fault", 64'(fault), 64'd0);
    chk("R7", "zero page_size", 64'(page_size), 64'd0);
    chk("R7", "raddr is rpn", 64'(raddr), 64'h5555_5000);
    chk("R2", "leaf_addr", 64'(leaf_addr), 64'(56'h100000 + 56'hABC * 8));
  endtask

  task automatic t_invalid();
    logic [63:0] a = 64'h0000_0000_1111_2222;
    int rd;
    mem.delete();
    nl[0] = 9; nl[1] = 9;
    build(a, 30, 56'h100000, 1, 64'h4000_0000_ABCD_E000);
    run_walk(a, 56'h100000, 9, 30, rd);
    chk("R6", "fault", 64'(fault), 64'd2);
    chk("R6", "reads", 64'(rd), 64'd2);
    chk("R6", "no result", 64'(raddr), 64'd0);
  endtask

  task automatic t_small_root();
    int rd;
    mem.delete();
    run_walk(64'h1234, 56'h100000, 4, 30, rd);
    chk("R5", "fault", 64'(fault), 64'd1);
    chk("R5", "reads", 64'(rd), 64'd0);
  endtask

  task automatic t_small_dir();
    logic [63:0] a = 64'h0000_0000_0765_4321;
    int rd;
    mem.delete();
    nl[0] = 9; nl[1] = 3;
    build(a, 30, 56'h100000, 1, 64'hC000_0000_0000_1000);
    run_walk(a, 56'h100000, 9, 30, rd);
    chk("R5", "dir fault", 64'(fault), 64'd1);
    chk("R5", "dir reads", 64'(rd), 64'd1);
  endtask

  task automatic t_too_wide();
    int rd;
    mem.delete();
    run_walk(64'h5678, 56'h100000, 20, 15, rd);
    chk("R7", "fault", 64'(fault), 64'd1);
    chk("R7", "reads", 64'(rd), 64'd0);
  endtask

  task automatic t_depth();
    logic [63:0] a = 64'h7FFF_FFFF_FFFF_FFFF;
    logic [63:0] lf = 64'hC000_0000_0000_0000;
    int rd;
    for (int i = 0; i < 9; i++) nl[i] = 5;
    mem.delete();
    build(a, 63, 56'h100000, 7, lf);
    run_walk(a, 56'h100000, 5, 63, rd);
    chk("R8", "leaf at last level fault", 64'(fault), 64'd0);
    chk("R8", "leaf at last level page", 64'(page_size), 64'd23);
    chk("R8", "leaf at last level reads", 64'(rd), 64'd8);
    mem.delete();
    build(a, 63, 56'h100000, 8, lf);
    run_walk(a, 56'h100000, 5, 63, rd);
    chk("R8", "too deep fault", 64'(fault), 64'd1);
    chk("R8", "too deep reads", 64'(rd), 64'd8);
  endtask

  task automatic t_slow_mem();
    logic [63:0] a = 64'h0000_0000_2AAA_5555;
    logic [63:0] lf = 64'hC000_0000_0BAD_0000;
    int rd;
    int h0;
    h0 = hold_err;
    lat = 4;
    mem.delete();
    nl[0] = 10; nl[1] = 8;
    build(a, 30, 56'h100000, 1, lf);
    run_walk(a, 56'h100000, 10, 30, rd);
    lat = 0;
    chk("R9", "held request", 64'(hold_err - h0), 64'd0);
    chk("R9", "slow raddr", 64'(raddr), 64'(f_raddr(lf, a, 12)));
    chk("R9", "slow reads", 64'(rd), 64'd2);
  endtask

  task automatic t_start_busy();
    logic [63:0] a = 64'h0000_0000_1357_9BDF;
    logic [63:0] lf = 64'hC000_0000_0C0F_F000;
    int n;
    int r0;
    r0 = rd_total;
    mem.delete();
    nl[0] = 9; nl[1] = 9;
    build(a, 30, 56'h100000, 1, lf);
    @(negedge clk);
    ea = a; root_base = 56'h100000; root_nls = 5'd9; tot_size = 6'd30;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10", "busy after start", 64'(busy), 64'd1);
    @(negedge clk);
    @(negedge clk);
    ea = 64'hFFFF_0000_FFFF_0000; root_nls = 5'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk("R9", "ignored start fault", 64'(fault), 64'd0);
    chk("R9", "ignored start raddr", 64'(raddr), 64'(f_raddr(lf, a, 12)));
    chk("R9", "ignored start reads", 64'(rd_total - r0), 64'd2);
    @(negedge clk);
    chk("R10", "done one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; ea = '0; root_base = '0;
    root_nls = '0; tot_size = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_two_level();
    t_three_level();
    t_root_leaf();
    t_exact_width();
    t_invalid();
    t_small_root();
    t_small_dir();
    t_too_wide();
    t_depth();
    t_slow_mem();
    t_start_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule